// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indication

This block compares the rising edges of a reference stream (`ref_in`) with those of a divided oscillator stream (`fb_in`) and reports which one runs ahead. Both inputs are sampled by a fast system clock through two-flop synchronisers. A rising edge on either input sets an internal "ahead" flag for that input. When both flags are set, a reset-delay counter runs for `RST_DLY` clocks and then clears both flags. Every comparison therefore ends with a coincident pulse of guaranteed width, and the detector has no dead zone.

The block has three kinds of output. Two active-low pulse outputs rest high. A single-ended pump output is encoded as an output enable (`pd_oe`) and a direction (`pd_up`); `pd_oe` low means high impedance. A lock output is the AND of the two pulse outputs, gated by an enable. An 8-bit control register selects polarity, output disable, standby and lock enable, and carries a 3-bit gain code that is passed straight out.

The block has no data stream, so there is no valid/ready handshake and no back-pressure. All pins are plain levels. The control register is loaded by a single-cycle write strobe, and the control write cannot stall.

Top module: `phase_freq_detector`

## Requirements
- R1: After reset the control register is zero. Both pulse outputs are high, `pd_oe` is 0, `lock_out` is 0 and `gain_sel` is 0.
- R2: With polarity (control bit 7) at 0, a rising edge on `fb_in` that arrives before one on `ref_in` drives `fb_pulse_n` low and leaves `ref_pulse_n` high. This holds until the matching `ref_in` edge arrives.
- R3: With polarity at 0, a rising edge on `ref_in` that arrives first drives `ref_pulse_n` low and leaves `fb_pulse_n` high.
- R4: With polarity at 1, the roles of the two pulse outputs are swapped. A leading `fb_in` drives `ref_pulse_n` low, and a leading `ref_in` drives `fb_pulse_n` low.
- R5: `pd_oe` is 1 exactly when one of the two ahead flags is set and the outputs are neither disabled nor in standby. `pd_up` equals the reference-ahead flag XOR polarity.
- R6: Once both flags are set, both pulse outputs stay low for exactly `RST_DLY` clocks. Both then return high unless a new edge arrives.
- R7: Control bit 6 (disable) forces both pulse outputs high and `pd_oe` to 0.
- R8: Control bit 4 (standby) forces both pulse outputs high and `pd_oe` to 0.
- R9: With control bit 5 at 1, `lock_out` equals `ref_pulse_n` AND `fb_pulse_n`. With bit 5 at 0, `lock_out` is a static 0.
- R10: `gain_sel` equals control bits 3..1. Bit 1 is the LSB.
- R11: The control register loads `ctl_wdata` on a rising clock edge with `ctl_wr` high. Without `ctl_wr`, a change on `ctl_wdata` has no effect.
- R12: An input rising edge takes effect at the outputs right after the third rising clock edge that follows it. An input held high, or a falling edge, creates no new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference edge stream (asynchronous) |
| fb_in | input | 1 | Divided oscillator edge stream (asynchronous) |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: 7 polarity, 6 disable, 5 lock enable, 4 standby, 3..1 gain, 0 unused |
| ref_pulse_n | output | 1 | Active-low reference-side pulse output |
| fb_pulse_n | output | 1 | Active-low feedback-side pulse output |
| pd_oe | output | 1 | Single-ended pump drive enable (0 = high impedance) |
| pd_up | output | 1 | Single-ended pump direction |
| lock_out | output | 1 | Lock indication |
| gain_sel | output | 3 | Gain code passed through from the control register |

## Verification
On every cycle the assertions check a set of invariants:
- disable and standby park the outputs at rest;
- lock stays low while it is not enabled, and is high only when both pulse outputs are high;
- an enabled pump output always matches exactly one active pulse output;
- the coincident pulse never ends early;
- the control register changes only on a write.

Only the bench scenarios can show the rest:
- which output fires for a given lead and polarity;
- the exact three-clock input latency;
- the exact width of the coincident pulse;
- that held or falling inputs create no event.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int CTL_W     = 8;
  localparam int POL_BIT   = 7;
  localparam int DIS_BIT   = 6;
  localparam int LDEN_BIT  = 5;
  localparam int STBY_BIT  = 4;
  localparam int GAIN_LSB  = 1;
  localparam int GAIN_W    = 3;

  typedef struct packed {
    logic              pol;
    logic              dis;
    logic              ld_en;
    logic              stby;
    logic [GAIN_W-1:0] gain;
  } ctl_t;

  function automatic ctl_t ctl_decode(input logic [CTL_W-1:0] w);
    ctl_t c;
    c.pol   = w[POL_BIT];
    c.dis   = w[DIS_BIT];
    c.ld_en = w[LDEN_BIT];
    c.stby  = w[STBY_BIT];
    c.gain  = w[GAIN_LSB +: GAIN_W];
    return c;
  endfunction
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic rise
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], d_async};
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core #(
  parameter int RST_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_r,
  input  logic rise_v,
  output logic flag_r,
  output logic flag_v
);
  localparam int CNT_W = (RST_DLY < 2) ? 1 : $clog2(RST_DLY);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_DLY - 1);

  logic [CNT_W-1:0] cnt_q;
  logic both, clr;

  assign both = flag_r & flag_v;
  assign clr  = both && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_r <= 1'b0;
      flag_v <= 1'b0;
      cnt_q  <= '0;
    end else begin
      flag_r <= (flag_r & ~clr) | rise_r;
      flag_v <= (flag_v & ~clr) | rise_v;
      cnt_q  <= (both && !clr) ? cnt_q + 1'b1 : '0;
    end
  end

  AST_COINCIDENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (both && cnt_q != LAST) |=> (flag_r && flag_v)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R6
  AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rise_r && !rise_v) |=> (!flag_r && !flag_v)); // R6
endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage
  import pfd_pkg::*;
(
  input  logic              flag_r,
  input  logic              flag_v,
  input  ctl_t              ctl,
  output logic              ref_pulse_n,
  output logic              fb_pulse_n,
  output logic              pd_oe,
  output logic              pd_up,
  output logic              lock_out,
  output logic [GAIN_W-1:0] gain_sel
);
  logic off, act_r, act_v;

  always_comb begin
    off         = ctl.dis | ctl.stby;
    act_r       = flag_r & ~off;
    act_v       = flag_v & ~off;
    ref_pulse_n = ~(ctl.pol ? act_v : act_r);
    fb_pulse_n  = ~(ctl.pol ? act_r : act_v);
    pd_oe       = (flag_r ^ flag_v) & ~off;
    pd_up       = flag_r ^ ctl.pol;
    lock_out    = ctl.ld_en & ref_pulse_n & fb_pulse_n;
    gain_sel    = ctl.gain;
  end
endmodule

// File: rtl/phase_freq_detector.sv
module phase_freq_detector
  import pfd_pkg::*;
#(
  parameter int RST_DLY     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              fb_in,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic              ref_pulse_n,
  output logic              fb_pulse_n,
  output logic              pd_oe,
  output logic              pd_up,
  output logic              lock_out,
  output logic [GAIN_W-1:0] gain_sel
);
  localparam int N_CH = 2;

  ctl_t ctl_q;
  logic [N_CH-1:0] in_vec, rise_vec;
  logic flag_r, flag_v;
  logic unused_wdata_bit;

  assign in_vec           = {fb_in, ref_in};
  assign unused_wdata_bit = ctl_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_decode(ctl_wdata);
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_sync
    pfd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_async(in_vec[g]), .rise(rise_vec[g])
    );
  end

  pfd_flag_core #(.RST_DLY(RST_DLY)) core_i (
    .clk(clk), .rst_n(rst_n),
    .rise_r(rise_vec[0]), .rise_v(rise_vec[1]),
    .flag_r(flag_r), .flag_v(flag_v)
  );

  pfd_out_stage out_i (
    .flag_r(flag_r), .flag_v(flag_v), .ctl(ctl_q),
    .ref_pulse_n(ref_pulse_n), .fb_pulse_n(fb_pulse_n),
    .pd_oe(pd_oe), .pd_up(pd_up), .lock_out(lock_out), .gain_sel(gain_sel)
  );

  AST_OFF_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.dis || ctl_q.stby) |-> (ref_pulse_n && fb_pulse_n && !pd_oe)); // R7
  AST_LOCK_STATIC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.ld_en |-> !lock_out); // R9
  AST_LOCK_NEEDS_REST: assert property (@(posedge clk) disable iff (!rst_n)
    lock_out |-> (ref_pulse_n && fb_pulse_n)); // R9
  AST_OE_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    pd_oe |-> (ref_pulse_n != fb_pulse_n)); // R5
  AST_CTL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ctl_q)); // R11
endmodule

// File: tb/phase_freq_detector_tb.sv
`timescale 1ns/1ps
module phase_freq_detector_tb_top;
  localparam int DLY = 4;

  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, fb_in = 1'b0, ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic ref_pulse_n, fb_pulse_n, pd_oe, pd_up, lock_out;
  logic [2:0] gain_sel;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phase_freq_detector #(.RST_DLY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ref_pulse_n(ref_pulse_n), .fb_pulse_n(fb_pulse_n),
    .pd_oe(pd_oe), .pd_up(pd_up), .lock_out(lock_out), .gain_sel(gain_sel)
  );

  // {ctl byte, lead_fb}
  localparam logic [8:0] VECS [0:7] = '{
    9'h040, 9'h041, 9'h140, 9'h141, 9'h001, 9'h080, 9'h061, 9'h11C
  };

  // expected {ref_n, fb_n, oe, up, lock}
  function automatic logic [4:0] expect_out(logic fr, logic fv, logic [7:0] c);
    logic off, pol, ar, av, rn, fn;
    pol = c[7]; off = c[6] | c[4];
    ar = fr & ~off; av = fv & ~off;
    rn = ~(pol ? av : ar); fn = ~(pol ? ar : av);
    return {rn, fn, (fr ^ fv) & ~off, fr ^ pol, c[5] & rn & fn};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {ref_pulse_n, fb_pulse_n, pd_oe, pd_up, lock_out};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic check_gain(string req, logic [2:0] exp);
    checks++;
    if (gain_sel !== exp) begin
      errors++;
      $display("FAIL %s: gain act=%0d exp=%0d", req, gain_sel, exp);
    end
  endtask

  task automatic write_ctl(logic [7:0] v);
    ctl_wdata = v; ctl_wr = 1'b1;
    tick(1);
    ctl_wr = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(1);
    check("R1 reset outputs", 5'b11000);
    check_gain("R1 reset gain", 3'd0);

    for (int i = 0; i < 8; i++) begin
      logic [7:0] c;
      logic lead_fb;
      c = VECS[i][8:1]; lead_fb = VECS[i][0];
      write_ctl(c);
      check_gain("R10 gain pass-through", c[3:1]);
      check("R9 idle lock level", expect_out(1'b0, 1'b0, c));
      if (lead_fb) fb_in = 1'b1; else ref_in = 1'b1;
      tick(2);
      check("R12 not yet visible", expect_out(1'b0, 1'b0, c));
      tick(1);
      check("R2 R3 R4 R5 R7 R8 lead phase", expect_out(!lead_fb, lead_fb, c));
      if (lead_fb) ref_in = 1'b1; else fb_in = 1'b1;
      tick(3);
      check("R6 coincident start", expect_out(1'b1, 1'b1, c));
      tick(DLY - 1);
      check("R6 coincident last cycle", expect_out(1'b1, 1'b1, c));
      tick(1);
      check("R6 coincident end", expect_out(1'b0, 1'b0, c));
      ref_in = 1'b0; fb_in = 1'b0;
      tick(4);
      check("R12 falling edges ignored", expect_out(1'b0, 1'b0, c));
    end

    // R11: data change without strobe has no effect
    write_ctl(8'h22);
    ctl_wdata = 8'hDF;
    tick(2);
    check_gain("R11 no write no load", 3'd1);
    check("R11 outputs unchanged", expect_out(1'b0, 1'b0, 8'h22));

    // R6 simultaneous edges, R12 held-high inputs
    ref_in = 1'b1; fb_in = 1'b1;
    tick(3);
    check("R6 simultaneous both low", expect_out(1'b1, 1'b1, 8'h22));
    tick(DLY - 1);
    check("R6 simultaneous still low", expect_out(1'b1, 1'b1, 8'h22));
    tick(1);
    check("R6 simultaneous cleared", expect_out(1'b0, 1'b0, 8'h22));
    tick(10);
    check("R12 held high no retrigger", expect_out(1'b0, 1'b0, 8'h22));
    ref_in = 1'b0; fb_in = 1'b0;

    // R1 again: reset clears control
    tick(3);
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    check("R1 re-reset outputs", 5'b11000);
    check_gain("R1 re-reset gain", 3'd0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule